// File: doc/BRIEF.md
# Configuration EEPROM Loader and Validator

After reset this block walks a fixed sequence of reads to bring up a network adapter's configuration. It first collects a board identity from a nibble-serial ID port, then reads words from a serial configuration EEPROM through a word-reader handshake. It decodes the shared-memory window from a run of set bits, checks an additive checksum over the whole EEPROM, extracts an interrupt code and maps it to a line number, and gathers the 48-bit station address. It also decides whether programmed I/O access must replace memory-mapped access.

The results appear on registered outputs. `done` rises once the sequence ends. `cfg_valid` marks a configuration that passed every check. `err_code` names the first check that failed. Both the EEPROM bit protocol and the ID-port hardware sit outside the block.

The sequencer states are S_START, S_ID_ASK, S_ID_WAIT, S_ID_CHECK, S_MEM_ASK, S_MEM_WAIT, S_MEM_CHECK, S_SUM_ASK, S_SUM_WAIT, S_SUM_CHECK, S_IRQ_ASK, S_IRQ_WAIT, S_MAC_ASK, S_MAC_WAIT, S_DONE and S_FAIL.

Transitions:
- S_START always moves to S_ID_ASK.
- Each *_ASK state issues one request and moves to its *_WAIT state.
- A *_WAIT state holds until the acknowledge arrives.
- S_ID_WAIT returns to S_ID_ASK until four nibbles are in, then moves to S_ID_CHECK.
- S_ID_CHECK goes to S_MEM_ASK on a match and to S_FAIL otherwise.
- S_MEM_WAIT moves to S_MEM_CHECK.
- S_MEM_CHECK goes to S_SUM_ASK, or to S_FAIL on a missing page or a bad run.
- S_SUM_WAIT loops back to S_SUM_ASK until the last word, then moves to S_SUM_CHECK.
- S_SUM_CHECK goes to S_IRQ_ASK, or to S_FAIL on a mismatch.
- S_IRQ_WAIT moves to S_MAC_ASK.
- S_MAC_WAIT loops back to S_MAC_ASK for three words, then moves to S_DONE.
- S_DONE and S_FAIL are held until reset.

Top module: `cfgl_loader`

## Requirements
- R1: The board ID is built from four ID-port reads. Each read places data bits 7:4 at bit position 4 × (bits 1:0), ORed into the ID. A result other than ID_CONST ends the load with err_code 1, and no EEPROM read is issued.
- R2: In the byte taken from bits 7:0 of EEPROM word MEMCFG_ADDR, the index of the lowest set bit is the page. A zero byte ends the load with err_code 2.
- R3: mem_base equals 0xC0000 + page × 0x4000.
- R4: The byte is shifted right by the page. The result 0x01, 0x03, 0x07 or 0x0F gives mem_size_kb 16, 32, 48 or 64. Any other result ends the load with err_code 3.
- R5: The 16-bit sum of EEPROM words 0 to 63 is taken with carries dropped. If it differs from ID_CONST, the load ends with err_code 4.
- R6: irq_code is (word CFG_ADDR AND IRQ_MASK) >> IRQ_SHIFT, 3 bits wide. irq_line is taken from the table 0, 9, 3, 4, 5, 10, 11, 0, indexed by that code.
- R7: station_addr is {word MAC_HI_ADDR, word MAC_MID_ADDR, word MAC_LO_ADDR}, so the upper byte of each word comes before its lower byte.
- R8: use_pio is 1 when mem_size_kb is 16 or less.
- R9: On success, done and cfg_valid are 1 and err_code is 0. On failure, done is 1, cfg_valid is 0 and the data outputs stay 0. Both outcomes are held until reset. The checks run in the order ID, page, size, checksum.
- R10: During and right after reset, done, cfg_valid and err_code are 0.
- R11: Each request is a one-cycle pulse. At most one request, to either the ID port or the EEPROM, is outstanding at a time. No request is made after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts a load |
| id_req | output | 1 | One-cycle request for one ID-port read |
| id_ack | input | 1 | ID-port byte valid |
| id_data | input | 8 | ID-port byte: nibble in 7:4, index in 1:0 |
| rd_req | output | 1 | One-cycle request for one EEPROM word |
| rd_addr | output | 6 | EEPROM word address, valid with rd_req |
| rd_ack | input | 1 | EEPROM word valid |
| rd_data | input | 16 | EEPROM word |
| done | output | 1 | Sequence finished |
| cfg_valid | output | 1 | All checks passed |
| err_code | output | 3 | First failed check: 0 none, 1 ID, 2 no page, 3 size, 4 checksum |
| mem_base | output | 20 | Shared-memory base address |
| mem_size_kb | output | 7 | Shared-memory size in KB |
| use_pio | output | 1 | Programmed I/O access required |
| irq_code | output | 3 | Raw interrupt code |
| irq_line | output | 4 | Translated interrupt line |
| station_addr | output | 48 | Station address, first byte in bits 47:40 |

## Verification
The bench overrides several parameters:
- the identity constant is 0x6D2B;
- the interrupt field is bits 10:8 of word 10;
- the address words are 16, 17 and 18.

These overrides show that field extraction follows the parameters and not fixed positions. The memory byte stays in word 6, and the default 64-word depth is kept, so the checksum runs over the full array and wraps many times. A word-reader latency of two cycles exercises the wait states. Shuffled nibble order, every interrupt code and each failure point are driven directly.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int CFG_BYTE_W  = 8;
    localparam int PAGE_W      = $clog2(CFG_BYTE_W);
    localparam int UNIT_CNT_W  = $clog2(CFG_BYTE_W + 1);
    localparam int MAX_UNITS   = 4;
    localparam int UNIT_KB     = 16;
    localparam int SIZE_W      = $clog2(MAX_UNITS * UNIT_KB + 1);
    localparam int BASE_W      = 20;
    localparam logic [BASE_W-1:0] BASE_ROOT = 20'hC0000;
    localparam logic [BASE_W-1:0] PAGE_SPAN = 20'h04000;
    localparam int IRQ_W       = 3;
    localparam int LINE_W      = 4;
    localparam int ERR_W       = 3;

    typedef enum logic [3:0] {
        S_START, S_ID_ASK, S_ID_WAIT, S_ID_CHECK,
        S_MEM_ASK, S_MEM_WAIT, S_MEM_CHECK,
        S_SUM_ASK, S_SUM_WAIT, S_SUM_CHECK,
        S_IRQ_ASK, S_IRQ_WAIT, S_MAC_ASK, S_MAC_WAIT,
        S_DONE, S_FAIL
    } ld_state_t;

    typedef enum logic [ERR_W-1:0] {
        E_NONE   = 3'd0,
        E_ID     = 3'd1,
        E_NOPAGE = 3'd2,
        E_SIZE   = 3'd3,
        E_SUM    = 3'd4
    } ld_err_t;

    function automatic logic [LINE_W-1:0] irq_to_line(input logic [IRQ_W-1:0] code);
        logic [LINE_W-1:0] line;
        unique case (code)
            3'd1:    line = 4'd9;
            3'd2:    line = 4'd3;
            3'd3:    line = 4'd4;
            3'd4:    line = 4'd5;
            3'd5:    line = 4'd10;
            3'd6:    line = 4'd11;
            default: line = 4'd0;
        endcase
        return line;
    endfunction

endpackage

// File: rtl/cfgl_id_assembler.sv
module cfgl_id_assembler #(
    parameter int ID_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            load,
    input  logic [7:0]      port_byte,
    output logic [ID_W-1:0] id_word
);
    localparam int NIB_W  = 4;
    localparam int SLICES = ID_W / NIB_W;
    localparam int IDX_W  = (SLICES > 1) ? $clog2(SLICES) : 1;

    logic [NIB_W-1:0] nib;
    logic [IDX_W-1:0] idx;
    logic             unused_mid;

    assign nib        = port_byte[7:4];
    assign idx        = port_byte[IDX_W-1:0];
    assign unused_mid = ^port_byte[3:IDX_W];

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                id_word[g*NIB_W +: NIB_W] <= '0;
            end else if (load && (idx == IDX_W'(g))) begin
                id_word[g*NIB_W +: NIB_W] <= id_word[g*NIB_W +: NIB_W] | nib;
            end
        end
    end

endmodule

// File: rtl/cfgl_window_decoder.sv
module cfgl_window_decoder
    import cfgl_pkg::*;
(
    input  logic [CFG_BYTE_W-1:0] cfg_byte,
    output logic                  page_found,
    output logic                  run_ok,
    output logic [BASE_W-1:0]     base_addr,
    output logic [SIZE_W-1:0]     size_kb
);
    logic [PAGE_W-1:0]     page;
    logic [CFG_BYTE_W-1:0] shifted;
    logic [UNIT_CNT_W-1:0] units;

    always_comb begin
        page_found = 1'b0;
        page       = '0;
        for (int i = CFG_BYTE_W - 1; i >= 0; i--) begin
            if (cfg_byte[i]) begin
                page_found = 1'b1;
                page       = PAGE_W'(i);
            end
        end
        shifted = cfg_byte >> page;
        units   = UNIT_CNT_W'($countones(shifted));
        run_ok  = page_found
                  && ((shifted & (shifted + CFG_BYTE_W'(1))) == '0)
                  && (int'(units) <= MAX_UNITS);
        base_addr = BASE_ROOT + BASE_W'(page) * PAGE_SPAN;
        size_kb   = SIZE_W'(units) * SIZE_W'(UNIT_KB);
    end

endmodule

// File: rtl/cfgl_sum_accum.sv
module cfgl_sum_accum #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] total
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            total <= '0;
        end else if (add) begin
            total <= total + word;
        end
    end
endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader
    import cfgl_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned WORDS       = 64,
    parameter logic [15:0] ID_CONST    = 16'h3E91,
    parameter int unsigned MEMCFG_ADDR = 6,
    parameter int unsigned CFG_ADDR    = 13,
    parameter logic [15:0] IRQ_MASK    = 16'hE000,
    parameter int unsigned IRQ_SHIFT   = 13,
    parameter int unsigned MAC_HI_ADDR = 2,
    parameter int unsigned MAC_MID_ADDR = 3,
    parameter int unsigned MAC_LO_ADDR = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    id_req,
    input  logic                    id_ack,
    input  logic [7:0]              id_data,
    output logic                    rd_req,
    output logic [$clog2(WORDS)-1:0] rd_addr,
    input  logic                    rd_ack,
    input  logic [WORD_W-1:0]       rd_data,
    output logic                    done,
    output logic                    cfg_valid,
    output logic [ERR_W-1:0]        err_code,
    output logic [BASE_W-1:0]       mem_base,
    output logic [SIZE_W-1:0]       mem_size_kb,
    output logic                    use_pio,
    output logic [IRQ_W-1:0]        irq_code,
    output logic [LINE_W-1:0]       irq_line,
    output logic [3*WORD_W-1:0]     station_addr
);
    localparam int AW        = $clog2(WORDS);
    localparam int CW        = AW;
    localparam int ID_NIBS   = 4;
    localparam int MAC_WORDS = 3;

    ld_state_t state, nxt_state;
    ld_err_t   nxt_err;

    logic [CW-1:0]           cnt;
    logic [CFG_BYTE_W-1:0]   cfg_byte;
    logic [IRQ_W-1:0]        irq_code_r;
    logic [3*WORD_W-1:0]     mac_sr;
    logic [WORD_W-1:0]       id_word;
    logic [WORD_W-1:0]       sum_total;
    logic                    page_found, run_ok;
    logic [BASE_W-1:0]       dec_base;
    logic [SIZE_W-1:0]       dec_size;
    logic [WORD_W-1:0]       irq_shifted;
    logic                    unused_irq;
    logic                    unused_mac;

    assign irq_shifted = (rd_data & WORD_W'(IRQ_MASK)) >> IRQ_SHIFT;
    assign unused_irq  = ^irq_shifted[WORD_W-1:IRQ_W];
    assign unused_mac  = ^mac_sr[3*WORD_W-1:2*WORD_W];

    cfgl_id_assembler #(.ID_W(WORD_W)) u_id (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == S_START),
        .load     ((state == S_ID_WAIT) && id_ack),
        .port_byte(id_data),
        .id_word  (id_word)
    );

    cfgl_window_decoder u_win (
        .cfg_byte  (cfg_byte),
        .page_found(page_found),
        .run_ok    (run_ok),
        .base_addr (dec_base),
        .size_kb   (dec_size)
    );

    cfgl_sum_accum #(.WORD_W(WORD_W)) u_sum (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(state == S_START),
        .add  ((state == S_SUM_WAIT) && rd_ack),
        .word (rd_data),
        .total(sum_total)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_START;
        else        state <= nxt_state;
    end

    // Next state and failure cause
    always_comb begin
        nxt_state = state;
        nxt_err   = E_NONE;
        unique case (state)
            S_START:    nxt_state = S_ID_ASK;
            S_ID_ASK:   nxt_state = S_ID_WAIT;
            S_ID_WAIT:  if (id_ack) nxt_state = (cnt == CW'(ID_NIBS - 1)) ? S_ID_CHECK : S_ID_ASK;
            S_ID_CHECK: begin
                if (id_word == WORD_W'(ID_CONST)) nxt_state = S_MEM_ASK;
                else begin nxt_state = S_FAIL; nxt_err = E_ID; end
            end
            S_MEM_ASK:  nxt_state = S_MEM_WAIT;
            S_MEM_WAIT: if (rd_ack) nxt_state = S_MEM_CHECK;
            S_MEM_CHECK: begin
                if (!page_found)  begin nxt_state = S_FAIL; nxt_err = E_NOPAGE; end
                else if (!run_ok) begin nxt_state = S_FAIL; nxt_err = E_SIZE; end
                else nxt_state = S_SUM_ASK;
            end
            S_SUM_ASK:  nxt_state = S_SUM_WAIT;
            S_SUM_WAIT: if (rd_ack) nxt_state = (cnt == CW'(WORDS - 1)) ? S_SUM_CHECK : S_SUM_ASK;
            S_SUM_CHECK: begin
                if (sum_total == WORD_W'(ID_CONST)) nxt_state = S_IRQ_ASK;
                else begin nxt_state = S_FAIL; nxt_err = E_SUM; end
            end
            S_IRQ_ASK:  nxt_state = S_IRQ_WAIT;
            S_IRQ_WAIT: if (rd_ack) nxt_state = S_MAC_ASK;
            S_MAC_ASK:  nxt_state = S_MAC_WAIT;
            S_MAC_WAIT: if (rd_ack) nxt_state = (cnt == CW'(MAC_WORDS - 1)) ? S_DONE : S_MAC_ASK;
            S_DONE:     nxt_state = S_DONE;
            S_FAIL:     nxt_state = S_FAIL;
            default:    nxt_state = S_FAIL;
        endcase
    end

    // Datapath: counter and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            cfg_byte   <= '0;
            irq_code_r <= '0;
            mac_sr     <= '0;
        end else begin
            unique case (state)
                S_ID_WAIT, S_SUM_WAIT, S_MAC_WAIT: begin
                    if ((state == S_ID_WAIT && id_ack) || (state != S_ID_WAIT && rd_ack)) begin
                        cnt <= (nxt_state == state) ? cnt : ((nxt_state == S_ID_ASK || nxt_state == S_SUM_ASK
                               || nxt_state == S_MAC_ASK) ? cnt + CW'(1) : '0);
                    end
                    if (state == S_MAC_WAIT && rd_ack) mac_sr <= {mac_sr[2*WORD_W-1:0], rd_data};
                end
                S_MEM_WAIT: if (rd_ack) cfg_byte <= rd_data[CFG_BYTE_W-1:0];
                S_IRQ_WAIT: if (rd_ack) begin
                    irq_code_r <= irq_shifted[IRQ_W-1:0];
                    cnt        <= '0;
                end
                default: ;
            endcase
        end
    end

    // Request outputs
    always_comb begin
        id_req  = (state == S_ID_ASK);
        rd_req  = 1'b0;
        rd_addr = '0;
        unique case (state)
            S_MEM_ASK: begin rd_req = 1'b1; rd_addr = AW'(MEMCFG_ADDR); end
            S_SUM_ASK: begin rd_req = 1'b1; rd_addr = cnt; end
            S_IRQ_ASK: begin rd_req = 1'b1; rd_addr = AW'(CFG_ADDR); end
            S_MAC_ASK: begin
                rd_req = 1'b1;
                unique case (cnt)
                    CW'(0):  rd_addr = AW'(MAC_HI_ADDR);
                    CW'(1):  rd_addr = AW'(MAC_MID_ADDR);
                    default: rd_addr = AW'(MAC_LO_ADDR);
                endcase
            end
            default: ;
        endcase
    end

    // Registered result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            cfg_valid    <= 1'b0;
            err_code     <= E_NONE;
            mem_base     <= '0;
            mem_size_kb  <= '0;
            use_pio      <= 1'b0;
            irq_code     <= '0;
            irq_line     <= '0;
            station_addr <= '0;
        end else if (state != S_DONE && nxt_state == S_DONE) begin
            done         <= 1'b1;
            cfg_valid    <= 1'b1;
            err_code     <= E_NONE;
            mem_base     <= dec_base;
            mem_size_kb  <= dec_size;
            use_pio      <= (dec_size <= SIZE_W'(UNIT_KB));
            irq_code     <= irq_code_r;
            irq_line     <= irq_to_line(irq_code_r);
            station_addr <= {mac_sr[2*WORD_W-1:0], rd_data};
        end else if (state != S_FAIL && nxt_state == S_FAIL) begin
            done     <= 1'b1;
            err_code <= nxt_err;
        end
    end

    // Assertions
    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, id_req}));
    a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_req && !id_req));
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(cfg_valid) && $stable(err_code) && $stable(station_addr)));
    a_r9_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (done && err_code == E_NONE));
    a_r9_fail_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_valid) |-> (err_code != E_NONE && mem_base == '0));
    a_r8_pio_small: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && use_pio) |-> (mem_size_kb <= SIZE_W'(UNIT_KB)));
    a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (mem_base[13:0] == '0 && mem_base >= BASE_ROOT));

endmodule

// File: tb/sim_cfgl_loader.sv
module sim_cfgl_loader;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam logic [15:0] ID_K = 16'h6D2B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_req, id_ack, rd_req, rd_ack;
    logic [7:0]  id_data;
    logic [5:0]  rd_addr;
    logic [15:0] rd_data;
    logic        done, cfg_valid, use_pio;
    logic [2:0]  err_code, irq_code;
    logic [19:0] mem_base;
    logic [6:0]  mem_size_kb;
    logic [3:0]  irq_line;
    logic [47:0] station_addr;

    logic [15:0] rom [64];
    logic [7:0]  id_bytes [4];
    int rd_count, id_count;
    int checks = 0, errors = 0;
    int line_tab [8] = '{0, 9, 3, 4, 5, 10, 11, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgl_loader #(
        .ID_CONST(ID_K), .CFG_ADDR(10), .IRQ_MASK(16'h0700), .IRQ_SHIFT(8),
        .MAC_HI_ADDR(16), .MAC_MID_ADDR(17), .MAC_LO_ADDR(18)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .id_req(id_req), .id_ack(id_ack), .id_data(id_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .done(done), .cfg_valid(cfg_valid), .err_code(err_code), .mem_base(mem_base),
        .mem_size_kb(mem_size_kb), .use_pio(use_pio), .irq_code(irq_code),
        .irq_line(irq_line), .station_addr(station_addr)
    );

    // Word reader and ID-port model
    initial begin
        rd_ack = 0; id_ack = 0; rd_data = '0; id_data = '0;
        forever begin
            @(negedge clk);
            rd_ack = 0; id_ack = 0;
            if (rst_n && rd_req) begin
                automatic logic [5:0] a = rd_addr;
                repeat (LAT) @(negedge clk);
                rd_data = rom[a]; rd_ack = 1; rd_count++;
            end else if (rst_n && id_req) begin
                repeat (LAT) @(negedge clk);
                id_data = id_bytes[id_count % 4]; id_ack = 1; id_count++;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_id(input int o0, input int o1, input int o2, input int o3);
        int ord [4];
        ord = '{o0, o1, o2, o3};
        for (int k = 0; k < 4; k++)
            id_bytes[k] = {ID_K[ord[k]*4 +: 4], 2'b00, 2'(ord[k])};
    endtask

    task automatic fix_sum();
        logic [15:0] s = '0;
        for (int k = 0; k < 63; k++) s = s + rom[k];
        rom[63] = ID_K - s;
    endtask

    task automatic fill(input logic [7:0] mbyte, input logic [2:0] code);
        for (int k = 0; k < 64; k++) rom[k] = 16'(k * 16'h1357 + 16'h0F0F);
        rom[6]  = {8'hA5, mbyte};
        rom[10] = 16'hF8C3 & ~16'h0700 | (16'(code) << 8);
        rom[16] = 16'h0A1B; rom[17] = 16'h2C3D; rom[18] = 16'h4E5F;
        fix_sum();
        set_id(0, 1, 2, 3);
    endtask

    task automatic run_load();
        int n = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rd_count = 0; id_count = 0;
        rst_n = 1;
        while (!done && n < 4000) begin @(negedge clk); n++; end
        chk("R9 done reached", done, 1);
    endtask

    task automatic expect_ok(input string tag, input logic [19:0] base, input int kb,
                             input logic pio, input int code);
        chk({tag, " R9 valid"}, cfg_valid, 1);
        chk({tag, " R9 err"}, err_code, 0);
        chk({tag, " R3 base"}, mem_base, base);
        chk({tag, " R4 size"}, mem_size_kb, kb);
        chk({tag, " R8 pio"}, use_pio, pio);
        chk({tag, " R6 code"}, irq_code, code);
        chk({tag, " R6 line"}, irq_line, line_tab[code]);
        chk({tag, " R7 mac"}, station_addr, 48'h0A1B2C3D4E5F);
        chk({tag, " R11 reads"}, rd_count, 69);
    endtask

    task automatic expect_err(input string tag, input int code, input int reads);
        chk({tag, " R9 code"}, err_code, code);
        chk({tag, " R9 valid low"}, cfg_valid, 0);
        chk({tag, " R9 data zero"}, {mem_base, station_addr[15:0]}, 0);
        chk({tag, " R11 reads"}, rd_count, reads);
        repeat (20) @(negedge clk);
        chk({tag, " R9 held"}, {done, err_code}, {1'b1, 3'(code)});
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R10 done in reset", done, 0);
        chk("R10 valid in reset", cfg_valid, 0);
        chk("R10 err in reset", err_code, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R10 after release", {done, cfg_valid, err_code}, 0);
    endtask

    task automatic t_good_sizes();
        fill(8'h3C, 3'd1); run_load(); expect_ok("64k", 20'hC8000, 64, 0, 1);
        fill(8'h80, 3'd5); run_load(); expect_ok("16k", 20'hDC000, 16, 1, 5);
        fill(8'h70, 3'd6); run_load(); expect_ok("48k", 20'hD0000, 48, 0, 6);
        fill(8'hC0, 3'd2); run_load(); expect_ok("32k", 20'hD8000, 32, 0, 2);
        fill(8'h01, 3'd3); run_load(); expect_ok("page0", 20'hC0000, 16, 1, 3);
    endtask

    task automatic t_irq_all();
        for (int c = 0; c < 8; c++) begin
            fill(8'h3C, 3'(c)); run_load();
            chk("R6 sweep code", irq_code, c);
            chk("R6 sweep line", irq_line, line_tab[c]);
        end
    endtask

    task automatic t_id();
        fill(8'h3C, 3'd1); set_id(2, 0, 3, 1); run_load();
        chk("R1 shuffled nibbles valid", cfg_valid, 1);
        fill(8'h3C, 3'd1); id_bytes[2] = id_bytes[2] ^ 8'h10; run_load();
        expect_err("R1 bad id", 1, 0);
        chk("R1 id reads", id_count, 4);
    endtask

    task automatic t_failures();
        fill(8'h00, 3'd1); run_load(); expect_err("R2 no page", 2, 1);
        fill(8'h2C, 3'd1); run_load(); expect_err("R4 gap in run", 3, 1);
        fill(8'h3F, 3'd1); run_load(); expect_err("R4 run too long", 3, 1);
        fill(8'h3C, 3'd1); rom[63] = rom[63] + 16'd1; run_load();
        expect_err("R5 checksum off by one", 4, 65);
        fill(8'h3C, 3'd1); rom[6] = rom[6] + 16'h0100; rom[7] = rom[7] - 16'h0100;
        run_load(); chk("R5 wrap sum valid", cfg_valid, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired R9 actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) rom[k] = '0;
        set_id(0, 1, 2, 3);
        t_reset();
        t_good_sizes();
        t_irq_all();
        t_id();
        t_failures();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule